// File: doc/BRIEF.md
# Dual Receive Buffer Controller

This block is the receive half of a small Ethernet MAC. A byte stream of received frames comes in, one byte per cycle, with a flag on the first byte and a flag on the last byte. Each frame is written into one of two packet buffers, with its four trailing FCS bytes kept in place. The block then raises that buffer's done bit. A processor reads the frame through a simple word bus and writes the done bit back to zero, which returns the buffer to the receiver.

A frame is only kept when its destination address equals the station address on `station_addr` or is the all-ones broadcast address. Frames alternate between the two buffers, so software can poll them in the same order. A frame that finds its intended buffer still owned by software moves to the other buffer. If neither buffer is free, the frame is discarded. When `DUAL` is 0 only the first buffer exists. CRC checking and PHY decoding are handled elsewhere.

Each buffer holds `DEPTH_WORDS` 32-bit words, and the last word of each buffer is its status register. `DEPTH_WORDS` must be a power of two. With the defaults, buffer A occupies 0x1000–0x17FF with status at 0x17FC, and buffer B occupies 0x1800–0x1FFF with status at 0x1FFC.

Top module: `rx_dual_buffer`

## Requirements
- R1: After reset, both status registers read 0, no buffer is owned and `rx_irq` is low.
- R2: Buffer A's data starts at `RX_BASE`. Buffer B's data starts at `RX_BASE + 4*DEPTH_WORDS`. Each buffer's status is at its base + 4*(DEPTH_WORDS-1). Frame byte k (counting from the first destination byte, FCS included) is stored in data word k/4, at bits [8*(k%4)+7 : 8*(k%4)]. Unused upper bytes of the final partial word read 0.
- R3: Status bit 0 (done) reads 1 from the clock edge that samples the last byte of an accepted frame, in the status word of the buffer that received the frame.
- R4: A bus write to a status word sets bit 3 (interrupt enable) to the written bit 3. Writing bit 0 as 0 clears done; writing it as 1 leaves done unchanged. Status reads return {28'b0, enable, 2'b00, done}.
- R5: When both buffers are free, successive accepted frames go to A, B, A, and so on. After each accepted frame, the next preferred buffer is the other one.
- R6: If the preferred buffer's done bit is set at the first byte, the frame goes to the other buffer when that one is free. If both done bits are set, the frame is dropped and neither status changes.
- R7: A buffer whose done bit is set is never written by the receiver. Its contents read back unchanged after any later frame.
- R8: A frame is accepted only if its first six bytes equal `station_addr` (bits 47:40 first) or are all 0xFF. A rejected frame sets no done bit, raises no interrupt and does not move the preferred buffer.
- R9: Frames shorter than 6 bytes, or longer than 4*(DEPTH_WORDS-1) bytes, are discarded. A frame of exactly 4*(DEPTH_WORDS-1) bytes is accepted.
- R10: `rx_irq` is high for exactly the one cycle in which a done bit rises, and only if that buffer's interrupt enable was 1.
- R11: With `DUAL` = 0, every accepted frame goes to buffer A. A frame that arrives while A is done is dropped, and the whole buffer B range reads 0.
- R12: Read data appears on `bus_rdata` one cycle after `bus_rd` and holds until the next read. Addresses outside the buffer window read 0.
- R13: A first-byte flag seen during a frame abandons the unfinished frame and starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| station_addr | input | 48 | Station address, first byte in bits 47:40 |
| bus_addr | input | ADDR_W | Byte address of the word access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| rx_irq | output | 1 | One-cycle receive interrupt |

## Verification
The bench builds two copies side by side from the same stimulus: one with `DUAL` = 1 and one with `DUAL` = 0. Both use `DEPTH_WORDS` = 16, which gives a 60-byte capacity. This small capacity puts the overflow boundary at 60 and 61 bytes within reach of short frames. The shared stimulus also exercises both the fallback path and the drop path when the single buffer is busy. A behavioural model tracks ownership, enables, the preferred buffer and stored bytes for each copy. The interrupt is compared against the model on every clock, and bus reads are compared against the model's view of the register map.

// File: rtl/rx_dual_buffer.sv
module rx_dual_buffer #(
  parameter int DUAL        = 1,
  parameter int DEPTH_WORDS = 512,
  parameter int ADDR_W      = 13,
  parameter int RX_BASE     = 32'h1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [47:0]       station_addr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              rx_irq
);

  localparam int NBUF      = (DUAL != 0) ? 2 : 1;
  localparam int IDX_W     = $clog2(DEPTH_WORDS);
  localparam int CNT_W     = IDX_W + 3;
  localparam int BUF_BYTES = DEPTH_WORDS * 4;
  localparam int MAX_BYTES = (DEPTH_WORDS - 1) * 4;
  localparam logic [IDX_W-1:0]  STAT_IDX = IDX_W'(DEPTH_WORDS - 1);
  localparam logic [ADDR_W-1:0] BASE     = ADDR_W'(RX_BASE);
  localparam logic [ADDR_W-1:0] SPAN     = ADDR_W'(NBUF * BUF_BYTES);
  localparam logic [CNT_W-1:0]  LIMIT    = CNT_W'(MAX_BYTES);

  // bus decode
  logic [ADDR_W-1:0] off;
  logic              in_win, a_sel, a_stat, a_data;
  logic [IDX_W-1:0]  a_idx;

  assign off    = bus_addr - BASE;
  assign in_win = (bus_addr >= BASE) && (off < SPAN);
  assign a_sel  = off[IDX_W+2];
  assign a_idx  = off[IDX_W+1:2];
  assign a_stat = in_win && (a_idx == STAT_IDX);
  assign a_data = in_win && (a_idx != STAT_IDX);

  // ownership state
  logic [1:0] done_q, ie_q;
  logic       nxt_q;

  // frame state
  logic             active_q, tgt_q, ok_q, hs_q, hb_q, ovf_q;
  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      acc_q;

  logic             starting, taking;
  logic             pick_t, pick_ok;
  logic             b_tgt, b_ok;
  logic [CNT_W-1:0] b_idx;
  logic             in_hdr, over;
  logic [7:0]       st_byte;
  logic             hs_n, hb_n, ovf_n;
  logic             wr_en, accept;
  logic [1:0]       lane;
  logic [IDX_W-1:0] w_idx;
  logic [31:0]      word_n;

  assign starting = rx_valid && rx_sof;
  assign taking   = rx_valid && (rx_sof || active_q);

  always_comb begin
    pick_t  = nxt_q;
    pick_ok = 1'b1;
    if (done_q[nxt_q]) begin
      if (NBUF == 2 && !done_q[~nxt_q]) pick_t = ~nxt_q;
      else                               pick_ok = 1'b0;
    end
  end

  assign b_tgt  = starting ? pick_t  : tgt_q;
  assign b_ok   = starting ? pick_ok : ok_q;
  assign b_idx  = starting ? '0      : cnt_q;
  assign in_hdr = b_idx < CNT_W'(6);
  assign over   = b_idx >= LIMIT;

  always_comb begin
    case (b_idx[2:0])
      3'd0:    st_byte = station_addr[47:40];
      3'd1:    st_byte = station_addr[39:32];
      3'd2:    st_byte = station_addr[31:24];
      3'd3:    st_byte = station_addr[23:16];
      3'd4:    st_byte = station_addr[15:8];
      default: st_byte = station_addr[7:0];
    endcase
  end

  assign hs_n  = (starting || hs_q) && (!in_hdr || rx_data == st_byte);
  assign hb_n  = (starting || hb_q) && (!in_hdr || rx_data == 8'hFF);
  assign ovf_n = (!starting && ovf_q) || over;

  assign lane   = b_idx[1:0];
  assign w_idx  = b_idx[IDX_W+1:2];
  assign word_n = ((lane == 2'd0) ? 32'h0 : acc_q) | (32'(rx_data) << (8 * lane));
  assign wr_en  = taking && b_ok && !over;
  assign accept = taking && rx_eof && b_ok && !ovf_n && (hs_n || hb_n) &&
                  (b_idx >= CNT_W'(5));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      tgt_q    <= 1'b0;
      ok_q     <= 1'b0;
      hs_q     <= 1'b0;
      hb_q     <= 1'b0;
      ovf_q    <= 1'b0;
      cnt_q    <= '0;
      acc_q    <= '0;
    end else if (taking) begin
      active_q <= !rx_eof;
      tgt_q    <= b_tgt;
      ok_q     <= b_ok;
      hs_q     <= hs_n;
      hb_q     <= hb_n;
      ovf_q    <= ovf_n;
      if (!over) begin
        cnt_q <= b_idx + CNT_W'(1);
        acc_q <= word_n;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= '0;
      ie_q   <= '0;
      nxt_q  <= 1'b0;
      rx_irq <= 1'b0;
    end else begin
      for (int b = 0; b < 2; b++) begin
        if (bus_wr && a_stat && a_sel == 1'(b)) ie_q[b] <= bus_wdata[3];
        done_q[b] <= (accept && b_tgt == 1'(b)) ||
                     (done_q[b] && !(bus_wr && a_stat && a_sel == 1'(b) && !bus_wdata[0]));
      end
      rx_irq <= accept && ie_q[b_tgt];
      if (accept) nxt_q <= (NBUF == 2) ? ~b_tgt : 1'b0;
    end
  end

  // buffer storage
  for (genvar b = 0; b < 2; b++) begin : g_buf
    if (b < NBUF) begin : g_slot
      logic [31:0] mem [DEPTH_WORDS];
      logic [31:0] q;
      always_ff @(posedge clk) begin
        if (wr_en && b_tgt == 1'(b)) mem[w_idx] <= word_n;
        if (bus_rd && a_data && a_sel == 1'(b)) q <= mem[a_idx];
      end
    end else begin : g_slot
      logic [31:0] q;
      assign q = '0;
    end
  end

  // read return
  logic [1:0]  rkind_q;
  logic        rsel_q;
  logic [31:0] rstat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rkind_q <= 2'd0;
      rsel_q  <= 1'b0;
      rstat_q <= '0;
    end else if (bus_rd) begin
      rkind_q <= a_data ? 2'd1 : (a_stat ? 2'd2 : 2'd0);
      rsel_q  <= a_sel;
      rstat_q <= {28'h0, ie_q[a_sel], 2'b00, done_q[a_sel]};
    end
  end

  assign bus_rdata = (rkind_q == 2'd1) ? (rsel_q ? g_buf[1].g_slot.q : g_buf[0].g_slot.q) :
                     (rkind_q == 2'd2) ? rstat_q : 32'h0;

endmodule

// File: rtl/rx_dual_buffer_chk.sv
module rx_dual_buffer_chk #(
  parameter int DUAL = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic       rx_eof,
  input logic       bus_wr,
  input logic       rx_irq,
  input logic [1:0] done,
  input logic       wr_en,
  input logic       wbuf
);

  assert_done_on_last_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(done & ~$past(done))) |-> $past(rx_valid && rx_eof));

  assert_release_by_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(done) & ~done)) |-> $past(bus_wr));

  assert_no_write_owned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !done[wbuf]);

  assert_irq_with_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> ($countones(done & ~$past(done)) == 1));

  assert_irq_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);

  if (DUAL == 0) begin : g_single
    assert_single_b_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !done[1]);
  end

endmodule

bind rx_dual_buffer rx_dual_buffer_chk #(.DUAL(DUAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_eof(rx_eof),
  .bus_wr(bus_wr), .rx_irq(rx_irq), .done(done_q), .wr_en(wr_en), .wbuf(b_tgt)
);

// File: tb/tb_rx_dual_buffer.sv
module tb_rx_dual_buffer;

  localparam int DW    = 16;
  localparam int BB    = DW * 4;
  localparam int BASE  = 32'h1000;
  localparam int STA_A = BASE + BB - 4;
  localparam int STA_B = BASE + 2 * BB - 4;
  localparam logic [47:0] STA = 48'h02_1A_2B_3C_4D_5E;
  localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;

  typedef logic [7:0] bq_t[$];

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [12:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd0, rd1;
  logic        irq0, irq1;

  always #10 clk = ~clk;

  rx_dual_buffer #(.DUAL(1), .DEPTH_WORDS(DW), .ADDR_W(13), .RX_BASE(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .station_addr(STA), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rd0), .rx_irq(irq0));

  rx_dual_buffer #(.DUAL(0), .DEPTH_WORDS(DW), .ADDR_W(13), .RX_BASE(BASE)) dut_single (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .station_addr(STA), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rd1), .rx_irq(irq1));

  // behavioural model, index [copy][buffer]
  logic [7:0] mm [2][2][64];
  int         ml [2][2];
  bit         md [2][2];
  bit         mie[2][2];
  bit         mnxt[2];
  bit         irq_due[2];
  int         n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bq_t mk(input logic [47:0] da, input int n, input int seed);
    bq_t f;
    for (int k = 0; k < n; k++)
      f.push_back(k < 6 ? da[47-8*k -: 8] : 8'((seed * 31 + k * 7) & 255));
    return f;
  endfunction

  function automatic void model_frame(input int i, input bq_t f);
    int n = f.size();
    bit hit = 1, bc = 1, ok = 1;
    int t;
    if (n < 6 || n > BB - 4) return;
    for (int k = 0; k < 6; k++) begin
      if (f[k] != STA[47-8*k -: 8]) hit = 0;
      if (f[k] != 8'hFF) bc = 0;
    end
    if (!hit && !bc) return;
    t = int'(mnxt[i]);
    if (md[i][t]) begin
      if (i == 0 && !md[i][1-t]) t = 1 - t;
      else ok = 0;
    end
    if (!ok) return;
    for (int k = 0; k < n; k++) mm[i][t][k] = f[k];
    ml[i][t]   = n;
    md[i][t]   = 1;
    irq_due[i] = mie[i][t];
    mnxt[i]    = (i == 0) ? bit'(1 - t) : 1'b0;
  endfunction

  function automatic logic [31:0] exp_rd(input int i, input int a);
    int nb = (i == 0) ? 2 : 1;
    int o = a - BASE, b, w;
    logic [31:0] v = '0;
    if (a < BASE || o >= nb * BB) return 32'h0;
    b = o / BB;
    w = (o % BB) / 4;
    if (w == DW - 1) return {28'h0, mie[i][b], 2'b00, md[i][b]};
    for (int j = 0; j < 4; j++)
      if (4 * w + j < ml[i][b]) v[8*j +: 8] = mm[i][b][4*w+j];
    return v;
  endfunction

  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      check(irq0 == irq_due[0], "R10 irq dual", 32'(irq0), 32'(irq_due[0]));
      check(irq1 == irq_due[1], "R10 irq single", 32'(irq1), 32'(irq_due[1]));
      irq_due[0] = 0;
      irq_due[1] = 0;
    end
  end

  task automatic send(input bq_t f, input bit with_eof);
    for (int k = 0; k < f.size(); k++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = f[k];
      rx_sof   = (k == 0);
      rx_eof   = with_eof && (k == f.size() - 1);
    end
    if (with_eof) begin
      model_frame(0, f);
      model_frame(1, f);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 13'(a); bus_wdata = d;
    for (int i = 0; i < 2; i++) begin
      int nb = (i == 0) ? 2 : 1;
      int o = a - BASE;
      if (a >= BASE && o < nb * BB && (o % BB) / 4 == DW - 1) begin
        md[i][o/BB]  = md[i][o/BB] && d[0];
        mie[i][o/BB] = d[3];
      end
    end
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int a);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 13'(a);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_rd(input int a, input string req);
    bus_read(a);
    check(rd0 === exp_rd(0, a), {req, " dual"}, rd0, exp_rd(0, a));
    check(rd1 === exp_rd(1, a), {req, " single"}, rd1, exp_rd(1, a));
  endtask

  task automatic chk_buf(input int b, input string req);
    for (int w = 0; w < DW - 1; w++) begin
      int a = BASE + b * BB + 4 * w;
      bit c0 = 4 * w < ml[0][b];
      bit c1 = (b == 1) || (4 * w < ml[1][b]);
      if (c0 || c1) begin
        bus_read(a);
        if (c0) check(rd0 === exp_rd(0, a), {req, " data dual"}, rd0, exp_rd(0, a));
        if (c1) check(rd1 === exp_rd(1, a), {req, " data single"}, rd1, exp_rd(1, a));
      end
    end
  endtask

  task automatic release_all();
    bus_write(STA_A, 32'h8);
    bus_write(STA_B, 32'h8);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      mnxt[i] = 0; irq_due[i] = 0;
      for (int b = 0; b < 2; b++) begin
        md[i][b] = 0; mie[i][b] = 0; ml[i][b] = 0;
      end
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_rd(STA_A, "R1");
    chk_rd(STA_B, "R1");
    check(irq0 == 1'b0 && irq1 == 1'b0, "R1 irq", 32'({irq0, irq1}), 32'h0);

    // R4 enable bit
    bus_write(STA_A, 32'h8);
    bus_write(STA_B, 32'h8);
    chk_rd(STA_A, "R4");

    // R2 R3 first frame, partial last word
    send(mk(STA, 13, 1), 1'b1);
    chk_rd(STA_A, "R3");
    bus_read(BASE);
    check(rd0 == 32'h3C2B1A02, "R2 byte order", rd0, 32'h3C2B1A02);
    chk_buf(0, "R2");

    // R5 alternate, R6/R11 single copy drops while A owned
    send(mk(BC, 20, 2), 1'b1);
    chk_rd(STA_B, "R5");
    chk_rd(STA_A, "R6");
    chk_buf(1, "R5");

    // R6 R7 both owned: dropped, contents unchanged
    send(mk(STA, 24, 3), 1'b1);
    chk_buf(0, "R7");
    chk_buf(1, "R7");
    chk_rd(STA_A, "R6");
    chk_rd(STA_B, "R6");

    // R5 release A, next frame lands in A
    bus_write(STA_A, 32'h8);
    chk_rd(STA_A, "R4");
    send(mk(STA, 30, 4), 1'b1);
    chk_buf(0, "R5");

    // R4 writing 1 to done does not set it
    bus_write(STA_A, 32'h8);
    bus_write(STA_A, 32'h9);
    chk_rd(STA_A, "R4");

    // R6 preferred B owned, falls back to A
    send(mk(STA, 17, 5), 1'b1);
    chk_rd(STA_A, "R6");
    chk_rd(STA_B, "R6");
    chk_buf(0, "R6");
    release_all();

    // R8 filtering
    send(mk(STA ^ 48'h1, 16, 6), 1'b1);
    chk_rd(STA_A, "R8");
    chk_rd(STA_B, "R8");
    send(mk(BC, 8, 7), 1'b1);
    chk_rd(STA_A, "R8");
    chk_rd(STA_B, "R8");
    release_all();

    // R9 length limits
    send(mk(STA, 5, 8), 1'b1);
    chk_rd(STA_A, "R9");
    chk_rd(STA_B, "R9");
    send(mk(STA, 6, 9), 1'b1);
    chk_rd(STA_A, "R9");
    chk_rd(STA_B, "R9");
    release_all();
    send(mk(STA, BB - 3, 10), 1'b1);
    chk_rd(STA_A, "R9");
    chk_rd(STA_B, "R9");
    send(mk(STA, BB - 4, 11), 1'b1);
    chk_rd(STA_A, "R9");
    chk_rd(STA_B, "R9");
    chk_buf(0, "R9");
    chk_buf(1, "R9");
    release_all();

    // R13 restart on a new first byte
    send(mk(STA, 10, 12), 1'b0);
    send(mk(STA, 14, 13), 1'b1);
    chk_rd(STA_A, "R13");
    chk_rd(STA_B, "R13");
    chk_buf(0, "R13");
    chk_buf(1, "R13");
    release_all();

    // R10 enable off: done rises without interrupt
    bus_write(STA_A, 32'h0);
    bus_write(STA_B, 32'h0);
    send(mk(BC, 12, 14), 1'b1);
    chk_rd(STA_A, "R10");
    chk_rd(STA_B, "R10");

    // R11 R12 window edges
    chk_rd(STA_B, "R11");
    chk_rd(BASE + BB, "R11");
    chk_rd(BASE - 4, "R12");
    chk_rd(BASE + 2 * BB, "R12");
    @(negedge clk);
    check(rd0 == exp_rd(0, BASE + 2 * BB), "R12 hold", rd0, 32'h0);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule